// File: doc/BRIEF.md
# Streaming GF(2^128) Universal Hash Engine

This block folds a stream of 128-bit blocks into a single 128-bit universal hash value over GF(2^128). A caller first presents the hash subkey, then any number of authenticated-only data blocks, then any number of ciphertext blocks. It finishes with one closing block that carries the two bit lengths. Each absorbed block is XORed into a running accumulator, and the sum is multiplied by the subkey in the field.

Blocks enter over a valid/ready handshake. A two-bit kind field says what each block is. A byte count marks how much of a short final block is real data. The multiplier works one bit per cycle, so the input stalls while a product is being formed. When the closing block's product is written back, a one-cycle completion pulse is raised. The hash stays on the output until the next subkey arrives. Blocks that arrive out of phase order are consumed and discarded.

Top module: `ghash_core`

## Requirements
- R1: While reset is held and right after it, `hash_out` is zero, `done` is low, and `in_ready` is high once reset has been released.
- R2: A handshake with `in_type` = 0 (subkey) loads `in_data` as the multiplier H and clears the accumulator. This can happen in any phase. `hash_out` reads zero on the cycle after acceptance.
- R3: A block with `in_type` = 1 (authenticated data) or 2 (ciphertext) that is accepted in a legal phase replaces the accumulator X with (X xor B)·H. The product is taken modulo x^128+x^7+x^2+x+1, and the leftmost (most significant) vector bit is the x^0 coefficient.
- R4: For kinds 1 and 2, `in_nbytes` = n keeps the leftmost n bytes of `in_data`, where byte j occupies bits 127−8j down to 120−8j. All later bytes are treated as zero. With n = 0 the block is all zero, and with n ≥ 16 it is used whole.
- R5: A block with `in_type` = 3 (closing) is absorbed whole. Its upper 64 bits hold the data bit length and its lower 64 bits hold the ciphertext bit length. When its product is written, `done` is high for exactly one cycle and `hash_out` carries the final hash.
- R6: After a block is accepted for multiplication, `in_ready` stays low for exactly W+1 cycles (129 by default). Otherwise `in_ready` is high.
- R7: An authenticated-data block that arrives after any ciphertext or closing block is accepted but ignored. It has no effect on the result, and `in_ready` stays high.
- R8: Before any subkey, and after a closing block, every block of kind 1, 2 or 3 is accepted and ignored. In those cases `hash_out` does not change and `done` stays low.
- R9: After the completion pulse, `hash_out` holds its value until the next subkey is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Block offered |
| in_ready | output | 1 | Block can be taken this cycle |
| in_type | input | 2 | 0 subkey, 1 authenticated data, 2 ciphertext, 3 closing lengths |
| in_data | input | W (128) | Block contents, byte 0 leftmost |
| in_nbytes | input | $clog2(W/8)+1 (5) | Valid leading bytes of a data or ciphertext block |
| hash_out | output | W (128) | Accumulator; the final hash once `done` has pulsed |
| done | output | 1 | One-cycle pulse when the closing product is written |

## Verification
The assertions assume that a new product is requested only when the serial multiplier is idle and not in its write-back cycle. They also assume that every block is held on the inputs until `in_ready` takes it. The bench drives each block at a falling edge and holds it until it samples `in_ready` high. It then releases the block right after the accepting edge, so no block is offered mid-product. The bench sweeps the data and ciphertext block counts and short final lengths against a bit-serial field model of its own. Separate runs cover out-of-phase blocks, a zero-length block, the stall length, and a restart by a new subkey.

// File: rtl/ghash_pkg.sv
package ghash_pkg;

  typedef enum logic [1:0] {
    BK_KEY = 2'd0,
    BK_AAD = 2'd1,
    BK_CT  = 2'd2,
    BK_LEN = 2'd3
  } blk_kind_e;

  typedef enum logic [1:0] {
    PH_NOKEY = 2'd0,
    PH_AAD   = 2'd1,
    PH_CT    = 2'd2,
    PH_FIN   = 2'd3
  } phase_e;

endpackage

// File: rtl/ghash_rst_sync.sv
module ghash_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/ghash_pad.sv
module ghash_pad #(
  parameter int W   = 128,
  parameter int NB  = W / 8,
  parameter int NBW = $clog2(NB) + 1
) (
  input  logic [W-1:0]   blk_i,
  input  logic [NBW-1:0] nbytes_i,
  output logic [W-1:0]   blk_o
);
  for (genvar j = 0; j < NB; j++) begin : g_byte
    assign blk_o[W-1-8*j -: 8] = (nbytes_i > NBW'(j)) ? blk_i[W-1-8*j -: 8] : 8'h00;
  end

  always_comb begin
    if (!$isunknown(nbytes_i) && nbytes_i == '0)
      a_r4_zero_len_blank : assert (blk_o == '0);
  end
endmodule

// File: rtl/ghash_gfmul_serial.sv
module ghash_gfmul_serial #(
  parameter int         W     = 128,
  parameter logic [W-1:0] RPOLY = {8'hE1, {(W-8){1'b0}}},
  parameter int         CW    = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic         start_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] h_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] prod_o
);
  logic [W-1:0]  x_q, x_n, v_q, v_n, z_q, z_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          busy_q, busy_n, done_q, done_n;
  logic [W-1:0]  z_step, v_step;
  logic          last_bit;

  assign z_step   = x_q[W-1] ? (z_q ^ v_q) : z_q;
  assign v_step   = v_q[0] ? ((v_q >> 1) ^ RPOLY) : (v_q >> 1);
  assign last_bit = (cnt_q == CW'(W - 1));

  always_comb begin
    x_n    = x_q;
    v_n    = v_q;
    z_n    = z_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (start_i) begin
      x_n    = a_i;
      v_n    = h_i;
      z_n    = '0;
      cnt_n  = '0;
      busy_n = 1'b1;
    end else if (busy_q) begin
      x_n   = x_q << 1;
      v_n   = v_step;
      z_n   = z_step;
      cnt_n = cnt_q + CW'(1);
      if (last_bit) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      x_q    <= '0;
      v_q    <= '0;
      z_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (start_i || busy_q) begin
        x_q   <= x_n;
        v_q   <= v_n;
        z_q   <= z_n;
        cnt_q <= cnt_n;
      end
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign prod_o = z_q;

  a_r6_start_when_idle : assert property (@(posedge clk) disable iff (!rst_sn)
    start_i |-> (!busy_q && !done_q));

  a_r6_done_after_busy : assert property (@(posedge clk) disable iff (!rst_sn)
    done_q |-> $past(busy_q));
endmodule

// File: rtl/ghash_core.sv
module ghash_core
  import ghash_pkg::*;
#(
  parameter int   W   = 128,
  localparam int  NB  = W / 8,
  localparam int  NBW = $clog2(NB) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [1:0]     in_type,
  input  logic [W-1:0]   in_data,
  input  logic [NBW-1:0] in_nbytes,
  output logic [W-1:0]   hash_out,
  output logic           done
);
  localparam logic [W-1:0] RPOLY = {8'hE1, {(W-8){1'b0}}};

  logic           rst_sn;
  blk_kind_e      kind;
  phase_e         phase_q, phase_n;
  logic [W-1:0]   acc_q, acc_n, h_q;
  logic           fin_pend_q, fin_pend_n, done_q, done_n;
  logic           accept, key_ld, use_blk, acc_we;
  logic [NBW-1:0] nb_eff;
  logic [W-1:0]   blk_pad;
  logic           mul_busy, mul_done;
  logic [W-1:0]   mul_prod;

  ghash_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign kind     = blk_kind_e'(in_type);
  assign in_ready = !mul_busy && !mul_done;
  assign accept   = in_valid && in_ready;
  assign key_ld   = accept && (kind == BK_KEY);

  always_comb begin
    use_blk = 1'b0;
    if (accept) begin
      unique case (kind)
        BK_AAD:  use_blk = (phase_q == PH_AAD);
        BK_CT:   use_blk = (phase_q == PH_AAD) || (phase_q == PH_CT);
        BK_LEN:  use_blk = (phase_q == PH_AAD) || (phase_q == PH_CT);
        default: use_blk = 1'b0;
      endcase
    end
  end

  assign nb_eff = (kind == BK_LEN) ? NBW'(NB) : in_nbytes;

  ghash_pad #(.W(W), .NB(NB), .NBW(NBW)) u_pad (
    .blk_i    (in_data),
    .nbytes_i (nb_eff),
    .blk_o    (blk_pad)
  );

  ghash_gfmul_serial #(.W(W), .RPOLY(RPOLY)) u_mul (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .start_i (use_blk),
    .a_i     (acc_q ^ blk_pad),
    .h_i     (h_q),
    .busy_o  (mul_busy),
    .done_o  (mul_done),
    .prod_o  (mul_prod)
  );

  always_comb begin
    phase_n    = phase_q;
    acc_n      = acc_q;
    fin_pend_n = fin_pend_q;
    done_n     = 1'b0;
    acc_we     = 1'b0;
    if (key_ld) begin
      phase_n    = PH_AAD;
      acc_n      = '0;
      fin_pend_n = 1'b0;
      acc_we     = 1'b1;
    end else if (use_blk) begin
      if (kind == BK_CT)  phase_n = PH_CT;
      if (kind == BK_LEN) begin
        phase_n    = PH_FIN;
        fin_pend_n = 1'b1;
      end
    end else if (mul_done) begin
      acc_n      = mul_prod;
      acc_we     = 1'b1;
      done_n     = fin_pend_q;
      fin_pend_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      phase_q    <= PH_NOKEY;
      acc_q      <= '0;
      fin_pend_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      phase_q    <= phase_n;
      fin_pend_q <= fin_pend_n;
      done_q     <= done_n;
      if (acc_we) acc_q <= acc_n;
    end
  end

  always_ff @(posedge clk) begin
    if (key_ld) h_q <= in_data;
  end

  assign hash_out = acc_q;
  assign done     = done_q;

  a_r2_key_clears : assert property (@(posedge clk) disable iff (!rst_sn)
    key_ld |=> (hash_out == '0 && !mul_busy));

  a_r5_done_pulse : assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done);

  a_r5_done_follows_mul : assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> $past(mul_done));

  a_r6_no_take_while_busy : assert property (@(posedge clk) disable iff (!rst_sn)
    mul_busy |-> !accept);

  a_r9_final_stable : assert property (@(posedge clk) disable iff (!rst_sn)
    (phase_q == PH_FIN && !fin_pend_q && !key_ld) |=> $stable(hash_out));

  a_r8_nokey_idle : assert property (@(posedge clk) disable iff (!rst_sn)
    (phase_q == PH_NOKEY) |-> (hash_out == '0 && !done));
endmodule

// File: tb/ghash_core_bench.sv
`timescale 1ns/1ps
module ghash_core_bench;
  localparam int W = 128;
  localparam int NBW = 5;
  localparam logic [127:0] RP = {8'hE1, 120'd0};

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, done;
  logic [1:0] in_type;
  logic [W-1:0] in_data, hash_out;
  logic [NBW-1:0] in_nbytes;

  int n_run = 0, n_fail = 0;
  logic [127:0] m_acc, m_h, rng;

  always #10 clk = ~clk;

  ghash_core u_ghash_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .in_data(in_data), .in_nbytes(in_nbytes),
    .hash_out(hash_out), .done(done)
  );

  function automatic logic [127:0] gfm(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] z = '0, v = b;
    for (int i = 0; i < 128; i++) begin
      if (a[127-i]) z ^= v;
      v = v[0] ? ((v >> 1) ^ RP) : (v >> 1);
    end
    return z;
  endfunction

  function automatic logic [127:0] padb(input logic [127:0] d, input int nb);
    logic [127:0] r = d;
    for (int j = 0; j < 16; j++) if (j >= nb) r[127-8*j -: 8] = 8'h00;
    return r;
  endfunction

  function automatic logic [127:0] step(input logic [127:0] s);
    logic [127:0] x = s;
    x ^= x << 13; x ^= x >> 7; x ^= x << 17; x ^= {x[63:0], x[127:64]};
    return x ^ 128'h9e3779b97f4a7c15f39cc0605cedc834;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] t, input logic [127:0] d, input int nb);
    @(negedge clk);
    in_valid = 1'b1; in_type = t; in_data = d; in_nbytes = NBW'(nb);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic absorb(input logic [1:0] t, input logic [127:0] d, input int nb);
    send(t, d, nb);
    m_acc = gfm(m_acc ^ padb(d, nb), m_h);
  endtask

  task automatic close_chk(input logic [63:0] la, input logic [63:0] lc, input string tag);
    int seen = 0;
    logic [127:0] fin;
    send(2'd3, {la, lc}, 3);
    m_acc = gfm(m_acc ^ {la, lc}, m_h);
    for (int k = 0; k < 400 && seen == 0; k++) begin
      if (done) seen = 1; else @(negedge clk);
    end
    chk(seen == 1, {"R5 done ", tag}, 128'(seen), 128'd1);
    chk(hash_out == m_acc, {"R3 R5 hash ", tag}, hash_out, m_acc);
    fin = hash_out;
    @(negedge clk);
    chk(done == 1'b0, {"R5 one-cycle ", tag}, 128'(done), 128'd0);
    repeat (4) @(negedge clk);
    chk(hash_out == fin, {"R9 hold ", tag}, hash_out, fin);
  endtask

  task automatic new_key();
    rng = step(rng);
    m_h = rng;
    m_acc = '0;
    send(2'd0, m_h, 16);
    chk(hash_out == '0, "R2 clear", hash_out, 128'd0);
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    int span;
    logic [127:0] keep;
    rng = 128'h0123456789abcdef0fedcba987654321;
    in_valid = 1'b0; in_type = 2'd0; in_data = '0; in_nbytes = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(hash_out == '0 && done == 1'b0, "R1 in reset", hash_out, 128'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready", 128'(in_ready), 128'd1);

    // R8: blocks before any subkey are dropped
    send(2'd1, 128'hdeadbeef, 16);
    chk(in_ready == 1'b1 && hash_out == '0, "R8 pre-key", hash_out, 128'd0);
    send(2'd3, 128'h80, 16);
    chk(in_ready == 1'b1 && done == 1'b0 && hash_out == '0, "R8 pre-key len", hash_out, 128'd0);

    // R6 stall span, R7 late data dropped
    new_key();
    rng = step(rng); absorb(2'd1, rng, 16);
    span = 0;
    while (!in_ready && span < 1000) begin span++; @(negedge clk); end
    chk(span == W + 1, "R6 stall span", 128'(span), 128'(W + 1));
    rng = step(rng); absorb(2'd2, rng, 16);
    rng = step(rng); send(2'd1, rng, 16);
    chk(in_ready == 1'b1, "R7 dropped no stall", 128'(in_ready), 128'd1);
    rng = step(rng); absorb(2'd2, rng, 9);
    close_chk(64'd128, 64'd200, "R7 mixed");

    // R8: after closing block
    keep = hash_out;
    send(2'd2, 128'h1234, 16);
    send(2'd3, 128'h55, 16);
    chk(hash_out == keep && done == 1'b0, "R8 post-final", hash_out, keep);

    // R4: zero-length and single-byte blocks
    new_key();
    absorb(2'd1, {128{1'b1}}, 0);
    absorb(2'd2, {128{1'b1}}, 1);
    close_chk(64'd0, 64'd8, "R4 short");

    // Sweep of block counts and last-block lengths
    for (int na = 0; na < 3; na++)
      for (int nc = 0; nc < 3; nc++)
        for (int t = 0; t < 2; t++) begin
          int la, lc;
          la = (t == 0) ? 16 : 1 + ((na + nc) * 5) % 15;
          lc = (t == 0) ? 16 : 1 + ((na * 3 + nc * 7) % 15);
          new_key();
          for (int i = 0; i < na; i++) begin
            rng = step(rng); absorb(2'd1, rng, (i == na - 1) ? la : 16);
          end
          for (int i = 0; i < nc; i++) begin
            rng = step(rng); absorb(2'd2, rng, (i == nc - 1) ? lc : 16);
          end
          close_chk(64'((na == 0) ? 0 : 128 * (na - 1) + 8 * la),
                    64'((nc == 0) ? 0 : 128 * (nc - 1) + 8 * lc), "R3 sweep");
        end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule